// File: doc/BRIEF.md
# Digital Clock and Data Recovery Loop

This block takes a sliced serial bit stream that carries timing jitter and rebuilds from it a bit clock and a retimed copy of the data. It runs from a fast sample clock. A programmable prescaler turns that clock into loop steps. On each step a phase accumulator advances by a nominal frequency word plus a loop correction. The top bit of the accumulator is the recovered bit clock, and the accumulator wrapping through zero marks the start of each bit.

When the input changes level, the accumulator value at that step is taken as a signed phase error. A proportional term nudges the phase once, by the error scaled down by a selectable power of two. An integral term, also scaled by a power of two, holds a frequency offset. That offset saturates at a clamp set as a fraction of the nominal step, so the loop cannot pull far from the programmed rate.

A free-run control holds the oscillator at the nominal rate and ignores data edges. A sampling control picks whether data is captured at the start of the bit or in its middle. If too many bit periods pass with no data transition, the loop restarts acquisition by itself. A lock flag reports a run of well-aligned edges. Every setting is a plain input port.

Top module: `cdr_loop`

## Requirements
- R1: The loop takes one step every N sample clocks. N is selected by `div_sel` codes 0..7 as 2, 4, 8, 16, 20, 32, 40, 48, so the recovered clock period is N × 2^24 / `freq_word` sample clocks.
- R2: While `free_run` is 1, each step adds exactly `freq_word` to the accumulator, data edges have no effect on the bit clock, and `locked` is 0 from the next step on. `bit_clk` is the inverse of accumulator bit 23.
- R3: A step where `din` differs from its value at the previous step is an edge. On an edge step (not free-run), the accumulator gains `freq_word` + integral − (E >>> `kp_sel`). E is the accumulator read as a signed 24-bit number before the step.
- R4: On each edge step the integral term becomes integral − (E >>> (`ki_sel` + 6)), saturated to ±(`freq_word` >> (`clamp_sel` + 3)). Steps without an edge add `freq_word` + integral.
- R5: `dout` captures `din` on the step where accumulator bit 23 falls 1→0 (`mid_sample` = 0) or rises 0→1 (`mid_sample` = 1). It holds between those steps.
- R6: `stop_sel` code 0 disables the auto restart. Codes 1, 2, 3 restart the loop after 2, 4, 8 bit starts (falls of bit 23) in a row with no edge. A restart clears the accumulator, the integral term and the lock count.
- R7: `locked` rises after 8 consecutive edge steps with E in [−2^22, 2^22). An edge outside that window clears the count.
- R8: Low `rst_n` (asynchronous) or high `loop_rst` (synchronous) clears the accumulator, integral term, prescaler, counters, `dout` and `locked`. Out of reset `bit_clk` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| loop_rst | input | 1 | Synchronous manual loop reset |
| din | input | 1 | Sliced serial data |
| freq_word | input | 24 | Nominal accumulator increment per step |
| div_sel | input | 3 | Prescaler code |
| kp_sel | input | 3 | Proportional divisor exponent |
| ki_sel | input | 3 | Integral divisor exponent (plus 6) |
| clamp_sel | input | 2 | Integral clamp code |
| stop_sel | input | 2 | Auto-restart code |
| free_run | input | 1 | Hold nominal rate, ignore edges |
| mid_sample | input | 1 | Sample mid-bit instead of at bit start |
| bit_clk | output | 1 | Recovered bit clock |
| dout | output | 1 | Retimed data |
| locked | output | 1 | Lock flag |

## Verification
Each result appears one sample clock after the step that causes it. `bit_clk` follows the accumulator written at that edge. `dout` changes on the edge that closes the sampling step. `locked` changes on the edge that closes the qualifying edge step, and a restart or reset clears everything on the following edge. The bench reference model advances on the same rising edge as the design and is compared at the falling edge, so every comparison falls inside the cycle where the result is due. Period, sampling and lock checks count whole falling-edge samples from a known bit-clock fall or stimulus change.

// File: rtl/cdr_loop.sv
module cdr_loop #(
  parameter int ACC_W      = 24,
  parameter int KI_SHIFT   = 6,
  parameter int LOCK_EDGES = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             loop_rst,
  input  logic             din,
  input  logic [ACC_W-1:0] freq_word,
  input  logic [2:0]       div_sel,
  input  logic [2:0]       kp_sel,
  input  logic [2:0]       ki_sel,
  input  logic [1:0]       clamp_sel,
  input  logic [1:0]       stop_sel,
  input  logic             free_run,
  input  logic             mid_sample,
  output logic             bit_clk,
  output logic             dout,
  output logic             locked
);
  localparam int MSB = ACC_W - 1;
  localparam int LW  = $clog2(LOCK_EDGES + 1);
  localparam logic [LW-1:0] LOCK_MAX = LW'(LOCK_EDGES);
  localparam logic signed [ACC_W-1:0] QTR = {2'b01, {(ACC_W-2){1'b0}}};

  logic [5:0]              pcnt, plim;
  logic [ACC_W-1:0]        acc, corr, acc_adv;
  logic signed [ACC_W-1:0] err, prop, idelta;
  logic signed [ACC_W:0]   integ, isum, isat, clampv;
  logic                    d_q;
  logic [3:0]              stop_cnt, stop_next, stop_lim;
  logic [LW-1:0]           good_cnt;
  logic                    step, trans, falls, rises, take, in_win, starved;

  always_comb begin
    case (div_sel)
      3'd0:    plim = 6'd1;
      3'd1:    plim = 6'd3;
      3'd2:    plim = 6'd7;
      3'd3:    plim = 6'd15;
      3'd4:    plim = 6'd19;
      3'd5:    plim = 6'd31;
      3'd6:    plim = 6'd39;
      default: plim = 6'd47;
    endcase
  end

  assign step    = pcnt >= plim;
  assign trans   = step && (din != d_q);
  assign err     = acc;
  assign prop    = err >>> kp_sel;
  assign idelta  = err >>> (ki_sel + KI_SHIFT);
  assign clampv  = $signed({1'b0, freq_word >> (3 + int'(clamp_sel))});
  assign isum    = integ - idelta;
  assign isat    = (isum > clampv) ? clampv : (isum < -clampv) ? -clampv : isum;
  assign corr    = free_run ? '0 : integ[MSB:0] - (trans ? $unsigned(prop) : '0);
  assign acc_adv = acc + freq_word + corr;
  assign falls   = step && acc[MSB] && !acc_adv[MSB];
  assign rises   = step && !acc[MSB] && acc_adv[MSB];
  assign take    = mid_sample ? rises : falls;
  assign in_win  = (err >= -QTR) && (err < QTR);

  assign stop_lim  = 4'd1 << stop_sel;
  assign stop_next = trans ? 4'd0 : falls ? stop_cnt + 4'd1 : stop_cnt;
  assign starved   = step && !free_run && (stop_sel != 2'd0) && (stop_next == stop_lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt <= '0; acc <= '0; integ <= '0; d_q <= 1'b0;
      stop_cnt <= '0; good_cnt <= '0; dout <= 1'b0;
    end else if (loop_rst) begin
      pcnt <= '0; acc <= '0; integ <= '0; d_q <= 1'b0;
      stop_cnt <= '0; good_cnt <= '0; dout <= 1'b0;
    end else begin
      pcnt <= step ? 6'd0 : pcnt + 6'd1;
      if (step) begin
        d_q <= din;
        if (take) dout <= din;
        if (starved) begin
          acc <= '0; integ <= '0; stop_cnt <= '0; good_cnt <= '0;
        end else if (free_run) begin
          acc <= acc_adv; integ <= '0; stop_cnt <= '0; good_cnt <= '0;
        end else begin
          acc      <= acc_adv;
          stop_cnt <= stop_next;
          if (trans) begin
            integ    <= isat;
            good_cnt <= !in_win ? '0 : (good_cnt == LOCK_MAX) ? good_cnt : good_cnt + 1'b1;
          end
        end
      end
    end
  end

  assign bit_clk = ~acc[MSB];
  assign locked  = good_cnt == LOCK_MAX;

  assert_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> pcnt == 6'd0) else $error("prescaler did not restart");

  assert_free_run_R2: assert property (@(posedge clk) disable iff (!rst_n)
    step && free_run && !loop_rst |=> acc == ACC_W'($past(acc) + $past(freq_word)))
    else $error("free-run step not nominal");

  assert_clamp_R4: assert property (@(posedge clk) disable iff (!rst_n)
    step && trans && !free_run && !loop_rst |=> (integ <= $past(clampv)) && (integ >= -$past(clampv)))
    else $error("integral beyond clamp");

  assert_dout_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dout) |-> $past(step) || $past(loop_rst))
    else $error("data changed off a step");

  assert_lock_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(trans)) else $error("lock rose without an edge");

  assert_reset_R8: assert property (@(posedge clk) disable iff (!rst_n)
    loop_rst |=> acc == '0 && integ == '0 && !locked && !dout)
    else $error("manual reset incomplete");
endmodule

// File: tb/tb_cdr_loop.sv
module tb_cdr_loop;
  localparam int CLK_PERIOD = 10;
  localparam longint MODV  = 64'd16777216;
  localparam longint HALFV = 64'd8388608;
  localparam longint QTRV  = 64'd4194304;

  logic clk = 0, rst_n = 0, loop_rst = 0, din = 0, free_run = 0, mid_sample = 0;
  logic [23:0] freq_word = 24'h100000;
  logic [2:0] div_sel = 0, kp_sel = 3'd1, ki_sel = 3'd2;
  logic [1:0] clamp_sel = 0, stop_sel = 0;
  logic bit_clk, dout, locked;

  int checks = 0, errors = 0;
  string tag = "R8";
  bit active = 0;
  logic [15:0] lfsr = 16'hACE1;

  cdr_loop dut (.clk(clk), .rst_n(rst_n), .loop_rst(loop_rst), .din(din),
    .freq_word(freq_word), .div_sel(div_sel), .kp_sel(kp_sel), .ki_sel(ki_sel),
    .clamp_sel(clamp_sel), .stop_sel(stop_sel), .free_run(free_run),
    .mid_sample(mid_sample), .bit_clk(bit_clk), .dout(dout), .locked(locked));

  always #(CLK_PERIOD/2) clk = ~clk;

  longint m_acc, m_integ;
  int m_pc, m_stop, m_good;
  bit m_d, m_dout;

  function automatic int div_n(input logic [2:0] c);
    case (c)
      3'd0: return 2;  3'd1: return 4;  3'd2: return 8;  3'd3: return 16;
      3'd4: return 20; 3'd5: return 32; 3'd6: return 40; default: return 48;
    endcase
  endfunction

  task automatic model_clear();
    m_acc = 0; m_integ = 0; m_pc = 0; m_stop = 0; m_good = 0; m_d = 0; m_dout = 0;
  endtask

  task automatic model_step();
    longint e, nxt, cl, isum;
    bit tr, mo, mn, bnd, smp;
    if (m_pc < div_n(div_sel) - 1) begin m_pc++; return; end
    m_pc = 0;
    e  = (m_acc >= HALFV) ? m_acc - MODV : m_acc;
    tr = (din != m_d);
    m_d = din;
    if (free_run) nxt = m_acc + freq_word;
    else nxt = m_acc + freq_word + m_integ - (tr ? (e >>> kp_sel) : 0);
    nxt = ((nxt % MODV) + MODV) % MODV;
    mo = m_acc >= HALFV; mn = nxt >= HALFV;
    bnd = mo && !mn;
    smp = mid_sample ? (!mo && mn) : bnd;
    if (smp) m_dout = din;
    if (free_run) begin
      m_acc = nxt; m_integ = 0; m_stop = 0; m_good = 0;
      return;
    end
    if (tr) begin
      cl = longint'(freq_word) >> (clamp_sel + 3);
      isum = m_integ - (e >>> (ki_sel + 6));
      if (isum > cl) isum = cl;
      if (isum < -cl) isum = -cl;
      m_integ = isum;
      m_stop = 0;
      if (e >= -QTRV && e < QTRV) m_good = (m_good < 8) ? m_good + 1 : 8;
      else m_good = 0;
    end else if (bnd) m_stop = (m_stop + 1) % 16;
    if (stop_sel != 0 && m_stop == (1 << stop_sel)) begin
      m_acc = 0; m_integ = 0; m_stop = 0; m_good = 0;
    end else m_acc = nxt;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n || loop_rst) model_clear();
    else model_step();
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (active) begin
    check(bit_clk == ~m_acc[23], tag, "bit_clk vs model", bit_clk, ~m_acc[23]);
    check(dout == m_dout, tag, "dout vs model", dout, m_dout);
    check(locked == (m_good == 8), tag, "locked vs model", locked, m_good == 8);
  end

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog run did not end");
    finish_run();
  end

  function automatic bit next_bit();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return lfsr[0];
  endfunction

  task automatic send(input int nbits, input int period, input bit alt, input bit jit);
    for (int i = 0; i < nbits; i++) begin
      din = alt ? ~din : next_bit();
      repeat (period + (jit ? ((i % 3) - 1) * 2 : 0)) @(negedge clk);
    end
  endtask

  task automatic measure(output int n);
    bit p;
    p = bit_clk;
    forever begin @(negedge clk); if (p && !bit_clk) break; p = bit_clk; end
    n = 0; p = bit_clk;
    forever begin @(negedge clk); n++; if (p && !bit_clk) break; p = bit_clk; end
  endtask

  initial begin
    int per;
    repeat (3) @(negedge clk);
    check(bit_clk == 1, "R8", "bit_clk in reset", bit_clk, 1);
    check(dout == 0, "R8", "dout in reset", dout, 0);
    check(locked == 0, "R8", "locked in reset", locked, 0);
    rst_n = 1; active = 1;

    tag = "R2"; free_run = 1;
    fork send(40, 30, 0, 1); join_none
    measure(per);
    check(per == 32, "R2", "free-run period", per, 32);
    measure(per);
    check(per == 32, "R2", "free-run period with data", per, 32);
    wait fork;
    check(locked == 0, "R2", "no lock in free run", locked, 0);

    tag = "R1"; div_sel = 3'd4;
    measure(per); measure(per);
    check(per == 320, "R1", "period with divide 20", per, 320);
    div_sel = 3'd7;
    measure(per); measure(per);
    check(per == 768, "R1", "period with divide 48", per, 768);
    div_sel = 3'd0;

    tag = "R5"; mid_sample = 0; din = 1;
    repeat (40) @(negedge clk);
    check(dout == 1, "R5", "bit-start sample", dout, 1);
    mid_sample = 1; din = 0;
    repeat (40) @(negedge clk);
    check(dout == 0, "R5", "mid-bit sample", dout, 0);

    tag = "R8"; din = 1; repeat (40) @(negedge clk);
    loop_rst = 1; @(negedge clk); loop_rst = 0;
    check(bit_clk == 1, "R8", "bit_clk after loop_rst", bit_clk, 1);
    check(dout == 0, "R8", "dout after loop_rst", dout, 0);
    din = 0;

    tag = "R3"; free_run = 0; mid_sample = 0; stop_sel = 0;
    send(60, 32, 1, 1);
    check(locked == 1, "R7", "lock after aligned edges", locked, 1);
    tag = "R5"; mid_sample = 1;
    send(30, 32, 0, 1);
    mid_sample = 0;

    tag = "R6"; stop_sel = 0;
    send(20, 32, 1, 0);
    repeat (640) @(negedge clk);
    check(locked == 1, "R6", "no restart when disabled", locked, 1);
    stop_sel = 2'd2;
    send(20, 32, 1, 0);
    repeat (40) @(negedge clk);
    check(locked == 1, "R6", "lock held before 4 idle bits", locked, 1);
    repeat (100) @(negedge clk);
    check(locked == 0, "R6", "restart after 4 idle bits", locked, 0);

    tag = "R7"; stop_sel = 0;
    send(40, 32, 1, 1);
    check(locked == 1, "R7", "relock", locked, 1);
    tag = "R8"; loop_rst = 1; @(negedge clk); loop_rst = 0;
    check(locked == 0, "R8", "lock cleared by loop_rst", locked, 0);

    tag = "R4"; clamp_sel = 2'd3; ki_sel = 3'd0;
    send(80, 34, 1, 0);
    clamp_sel = 2'd0;
    send(80, 34, 0, 1);
    kp_sel = 3'd3; ki_sel = 3'd4;
    send(60, 31, 1, 1);

    active = 0;
    finish_run();
  end
endmodule